// File: doc/BRIEF.md
# Radix-2 FFT Quarter Stage

This block is the next-to-last stage of a streaming radix-2 FFT. It accepts one packed complex sample on every cycle where the clock enable is high. It returns one packed complex result for each accepted sample. Each result combines two samples that stand `SPAN` apart in the stream. The only twiddle factors at this stage are 1 and -j, so no multiplier is needed. The -j rotation is a swap of the real and imaginary parts with one of them negated.

A frame starts with a one-cycle sync pulse on the first sample. Until the first sync after reset, the block accepts nothing. The output carries its own sync pulse on the first valid result of each frame, at a fixed number of accepted samples after the input sync. Each result is one bit wider per component than the input, so no rounding or saturation is needed.

A build-time parameter chooses the span. The default span is 2, which gives the quarter-stage ordering. A span of 1 gives the last-stage ordering, where adjacent samples form sum and difference pairs.

Top module: `fft_quarter_butterfly`

## Requirements
- R1: Packing. `din` is `{real, imag}`, each half IW bits in two's complement. `dout` is `{real, imag}`, each half IW+1 bits in two's complement. The real part is the upper half in both words.
- R2: With SPAN=2, let j be the result index counted from 0 at the first result of the frame. Results are formed in groups of four, and the base of result j is the multiple of 4 at or below j. At group positions j%4 = 0 and j%4 = 1, the result is x[j] + x[j+2], applied separately to the real and imaginary parts. Here x[0] is the sample that carried the sync.
- R3: With SPAN=2, at group position 2 the result is x[j-2] - x[j], the earlier sample minus the later one.
- R4: With SPAN=2, at group position 3 the difference d = x[j-2] - x[j] is rotated by -j. The result real part is imag(d) and the result imaginary part is -real(d).
- R5: Result j appears on `dout` right after the enabled edge that accepts sample x[j+5]. So result 0 appears after the 6th accepted sample of the frame, counting the sync sample as the first.
- R6: `sync_out` is high only while result 0 of a frame is on `dout`. It falls at the next enabled edge.
- R7: After reset and before the first sync, input samples are ignored. `dout` stays 0 and `sync_out` stays 0.
- R8: On a cycle with `ce` low, nothing advances. `dout` and `sync_out` hold their values, and `din` and `sync_in` have no effect.
- R9: A synchronous reset clears `dout` and `sync_out` and re-arms the wait for a first sync (R7).
- R10: Every sync pulse, not only the first, restarts the sample count at 0 and realigns the group position. It also produces a new `sync_out` per R5 and R6.
- R11: With SPAN=1, even positions give x[j] + x[j+1] and odd positions give x[j-1] - x[j]. Latency and sync follow R5 and R6.
- R12: Sums and differences are exact for all input values, including the most negative and most positive codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; one sample per high cycle |
| sync_in | input | 1 | Marks the first sample of a frame |
| din | input | 2*IW | Input sample {real, imag} |
| dout | output | 2*IW+2 | Result {real, imag} |
| sync_out | output | 1 | Marks the first result of a frame |

## Verification
Three kinds of input stream are used.

- **Impulse-like stream.** This is a sparse stream with single non-zero samples. Because most samples are zero, an error in the pairing distance or in the sign of a difference shows up as a result at the wrong position or with the wrong sign.
- **Counter-derived sweep.** This stream is long and crosses most value pairs of a 4-bit configuration. Its clock-enable gaps carry changing garbage on `din`. It separates the four group positions and shows any leak from a stalled cycle. A resync is placed in the middle of a group to check that the position counter realigns.
- **Extreme-value block.** This stream uses the most negative and most positive codes. It exposes any loss of the carry bit or any error in the negation during rotation.

Both span settings run side by side on the same stream.

// File: rtl/fft_quarter_butterfly.sv
module fft_quarter_butterfly #(
  parameter int IW   = 16,
  parameter int SPAN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sync_in,
  input  logic [2*IW-1:0]   din,
  output logic [2*IW+1:0]   dout,
  output logic              sync_out
);
  localparam int OW = IW + 1;
  localparam int EXTRA = 2 - SPAN;
  localparam logic [2:0] FIRST_OUT = 3'd5;
  localparam logic [2:0] LEAD_TOP  = 3'd6;

  logic [2:0] lead;
  logic [1:0] pos;
  logic       started, take;
  logic [1:0] cur;

  assign started = (lead != 3'd0);
  assign take    = ce && (sync_in || started);
  assign cur     = sync_in ? 2'd0 : pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead <= '0;
      pos  <= '0;
    end else if (take) begin
      pos <= cur + 2'd1;
      if (sync_in) lead <= 3'd1;
      else if (lead < LEAD_TOP) lead <= lead + 3'd1;
    end
  end

  logic signed [IW-1:0] in_re, in_im;
  logic signed [IW-1:0] dl_re [SPAN];
  logic signed [IW-1:0] dl_im [SPAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      in_re <= '0;
      in_im <= '0;
      for (int i = 0; i < SPAN; i++) begin
        dl_re[i] <= '0;
        dl_im[i] <= '0;
      end
    end else if (take) begin
      in_re    <= din[2*IW-1:IW];
      in_im    <= din[IW-1:0];
      dl_re[0] <= in_re;
      dl_im[0] <= in_im;
      for (int i = 1; i < SPAN; i++) begin
        dl_re[i] <= dl_re[i-1];
        dl_im[i] <= dl_im[i-1];
      end
    end
  end

  logic signed [OW-1:0] a_re, a_im, b_re, b_im;
  assign a_re = {dl_re[SPAN-1][IW-1], dl_re[SPAN-1]};
  assign a_im = {dl_im[SPAN-1][IW-1], dl_im[SPAN-1]};
  assign b_re = {in_re[IW-1], in_re};
  assign b_im = {in_im[IW-1], in_im};

  logic signed [OW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [OW-1:0] dd1_re, dd1_im, dd2_re, dd2_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_re <= '0; sum_im <= '0;
      dif_re <= '0; dif_im <= '0;
      dd1_re <= '0; dd1_im <= '0;
      dd2_re <= '0; dd2_im <= '0;
    end else if (take) begin
      sum_re <= a_re + b_re;
      sum_im <= a_im + b_im;
      dif_re <= a_re - b_re;
      dif_im <= a_im - b_im;
      dd1_re <= dif_re; dd1_im <= dif_im;
      dd2_re <= dd1_re; dd2_im <= dd1_im;
    end
  end

  logic signed [OW-1:0] sq_re, sq_im;
  generate
    if (EXTRA == 1) begin : g_sum_delay
      logic signed [OW-1:0] hold_re, hold_im;
      always_ff @(posedge clk) begin
        if (rst) begin
          hold_re <= '0;
          hold_im <= '0;
        end else if (take) begin
          hold_re <= sum_re;
          hold_im <= sum_im;
        end
      end
      assign sq_re = hold_re;
      assign sq_im = hold_im;
    end else begin : g_sum_direct
      assign sq_re = sum_re;
      assign sq_im = sum_im;
    end
  endgenerate

  logic sel_diff, rot;
  assign sel_diff = (SPAN == 2) ? cur[1] : cur[0];
  assign rot      = (SPAN == 2) && (cur == 2'd3);

  logic signed [OW-1:0] m_re, m_im;
  always_ff @(posedge clk) begin
    if (rst) begin
      m_re <= '0;
      m_im <= '0;
      dout <= '0;
    end else if (take) begin
      m_re <= sel_diff ? (rot ? dd2_im : dd2_re) : sq_re;
      m_im <= sel_diff ? (rot ? -dd2_re : dd2_im) : sq_im;
      dout <= {m_re, m_im};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_out <= 1'b0;
    else if (ce) sync_out <= take && !sync_in && (lead == FIRST_OUT);
  end

  a_r6_single_sync: assert property (@(posedge clk) disable iff (rst)
    (ce && sync_out) |=> !sync_out);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(dout) && $stable(sync_out)));

  a_r7_wait_quiet: assert property (@(posedge clk) disable iff (rst)
    !started |-> (dout == '0 && !sync_out));

  a_r10_sync_restart: assert property (@(posedge clk) disable iff (rst)
    (ce && sync_in) |=> (started && !sync_out));
endmodule

// File: tb/sim_fft_quarter_butterfly.sv
module sim_fft_quarter_butterfly;
  localparam int CLK_P = 10;
  localparam int IW = 4;
  localparam int HN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic sync_in = 1'b0;
  logic [2*IW-1:0] din = '0;
  logic [2*IW+1:0] dout0, dout1;
  logic sync0, sync1;

  always #(CLK_P/2) clk = ~clk;

  fft_quarter_butterfly #(.IW(IW), .SPAN(2)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .sync_in(sync_in), .din(din),
    .dout(dout0), .sync_out(sync0));
  fft_quarter_butterfly #(.IW(IW), .SPAN(1)) u1 (
    .clk(clk), .rst(rst), .ce(ce), .sync_in(sync_in), .din(din),
    .dout(dout1), .sync_out(sync1));

  int n_chk = 0;
  int n_fail = 0;
  int hre [HN];
  int him [HN];
  int kcnt = 0;
  bit armed = 0;
  string xtag = "";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s%s actual=%0h expected=%0h", req, xtag, act, exp);
    end
  endtask

  function automatic logic [2*IW+1:0] expv(input int s, input int j);
    int p, base, a, b, re, im, q;
    p = j % (2*s);
    base = j - p;
    if (p < s) begin
      a = base + p; b = a + s;
      re = hre[a] + hre[b];
      im = him[a] + him[b];
    end else begin
      q = p - s;
      a = base + q; b = a + s;
      re = hre[a] - hre[b];
      im = him[a] - him[b];
      if (s == 2 && p == 3) begin
        q = re; re = im; im = -q;
      end
    end
    return {re[IW:0], im[IW:0]};
  endfunction

  function automatic string rtag(input int s, input int j);
    if (s == 1) return "R11";
    case (j % 4)
      0, 1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step(input bit c, input bit s, input int re, input int im);
    logic [2*IW+1:0] p0, p1;
    bit ps0, ps1;
    int k;
    @(negedge clk);
    ce = c; sync_in = s; din = {re[IW-1:0], im[IW-1:0]};
    p0 = dout0; p1 = dout1; ps0 = sync0; ps1 = sync1;
    @(posedge clk);
    #(CLK_P/4);
    if (!c) begin
      chk(dout0 == p0 && sync0 == ps0, "R8", int'(dout0), int'(p0));
      chk(dout1 == p1 && sync1 == ps1, "R8", int'(dout1), int'(p1));
    end else if (s || armed) begin
      k = s ? 0 : kcnt;
      hre[k] = re; him[k] = im;
      kcnt = k + 1;
      armed = 1;
      chk(sync0 == (k == 5), (k == 5) ? "R5" : "R6", int'(sync0), int'(k == 5));
      chk(sync1 == (k == 5), (k == 5) ? "R5" : "R6", int'(sync1), int'(k == 5));
      if (k >= 5) begin
        chk(dout0 == expv(2, k-5), (k == 5) ? "R5" : rtag(2, k-5), int'(dout0), int'(expv(2, k-5)));
        chk(dout1 == expv(1, k-5), rtag(1, k-5), int'(dout1), int'(expv(1, k-5)));
      end
    end else begin
      chk(dout0 == '0 && !sync0, "R7", int'(dout0), 0);
      chk(dout1 == '0 && !sync1, "R7", int'(dout1), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ce = 1; sync_in = 0; din = 8'h5a;
    @(posedge clk);
    #(CLK_P/4);
    chk(dout0 == '0 && !sync0, "R9", int'(dout0), 0);
    chk(dout1 == '0 && !sync1, "R9", int'(dout1), 0);
    @(negedge clk);
    rst = 0; ce = 0;
    armed = 0; kcnt = 0;
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk(dout0 == '0 && !sync0, "R9", int'(dout0), 0);
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < 6; i++) step(1, 0, i - 3, 3 - i);

    // R1: known packing check
    step(1, 1, 3, -2);
    step(1, 0, 0, 0);
    step(1, 0, 1, 5);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    @(negedge clk);
    ce = 1; sync_in = 0; din = '0;
    @(posedge clk);
    #(CLK_P/4);
    chk(dout0 == 10'b00100_00011, "R1", int'(dout0), 10'b00100_00011);
    hre[5] = 0; him[5] = 0; kcnt = 6;

    step(1, 1, 7, 0);
    for (int i = 1; i < 40; i++)
      step(1, 0, (i % 5 == 0) ? (i % 8) : 0, (i % 7 == 2) ? -(i % 8) : 0);

    step(1, 1, 1, 1);
    for (int k = 1; k < 1024; k++) begin
      if (k == 601) step(1, 1, -8, 7);
      else step(1, 0, ((k ^ (k >> 3)) * 5) % 16 - 8, (((k >> 2) * 3) + k) % 16 - 8);
      if (k % 7 == 3)
        for (int g = 0; g <= k % 3; g++) step(0, g[0], k % 16, g);
    end

    xtag = "/R12";
    step(1, 1, -8, 7);
    for (int k = 1; k < 64; k++) begin
      if (k < 32) step(1, 0, (k % 4 < 2) ? -8 : 7, (k % 4 < 2) ? 7 : -8);
      else step(1, 0, (k % 8 < 4) ? -8 : 7, (k % 8 < 4) ? -8 : 7);
    end
    xtag = "";

    do_reset();
    for (int i = 0; i < 10; i++) step(1, 0, i, -i);
    step(1, 1, 2, 3);
    for (int i = 1; i < 20; i++) step(1, 0, i % 8, -(i % 8));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule